// File: doc/BRIEF.md
# Multiplier-Free Unity-Twiddle Butterfly Tree Engine

This block runs the part of a radix-2 decimation-in-frequency transform whose butterflies all use the unity twiddle factor. Those N-1 butterflies need only an add and a subtract. They form a binary tree: stage s has 2^s butterflies, and each one pairs the first point of a block of span N>>s with the point half a span further on. The engine does not make one memory round trip per butterfly. It groups the tree into nodes that each cover J = log2(R) stages. A node reads R points into a small local register file, runs its R-1 butterflies there level by level, and writes the R points back to the addresses they came from.

When log2(N) is not a multiple of J, the leftover top stages run first as a prolog. The prolog uses nodes of two points and one butterfly each. Tree levels are visited breadth-first: every node of one pass finishes before the next pass begins. Every butterfly output is halved by an arithmetic shift, so no result can overflow. A controller starts a run with a one-cycle `start` pulse. It sees the end of the run on a one-cycle `done` pulse. The engine drives one single-port sample memory that has a one-cycle read latency. It also reports how many reads and writes the run made.

The control is a five-state machine:
- IDLE waits for `start`; IDLE→LOAD on `start`.
- LOAD issues the node's reads and captures the returned data; LOAD→CALC once every point of the node is held.
- CALC applies one tree level per cycle; CALC→STORE after the last level.
- STORE writes the points back; STORE→LOAD for the next node, or STORE→FINISH after the last node of the last pass.
- FINISH raises `done`; FINISH→IDLE unconditionally.

Top module: `w0_tree_engine`

## Requirements
- R1: For each butterfly on inputs a (upper) and b (lower), the upper result is floor((a+b)/2) and the lower result is floor((a-b)/2). The real and imaginary parts are handled independently, and no multiplication is used.
- R2: After a run, memory holds exactly the result of applying R1 stage by stage for s = 0..log2(N)-1. Each stage uses, for every i0 that is a multiple of N>>s, the pair (i0, i0+(N>>s)/2).
- R3: The (log2(N) mod J) leftover top stages run first. Each prolog butterfly reads its two points in the order upper, lower, then writes them back in the same order.
- R4: A kernel node at span S with base address b reads addresses b + k·(S>>J) for k = 0..R-1 in increasing k. It performs R-1 butterflies in registers, then writes the same addresses in the same order. No cycle both reads and writes.
- R5: At `done`, rd_count and wr_count each equal R·(kernel nodes) + 2·(prolog butterflies). For N=32 and R=4 that is 42, from 2 prolog accesses plus 10 nodes.
- R6: Nodes are visited breadth-first. Within a pass, nodes go in increasing base address. The span shrinks by 2 per prolog pass and by 2^J per kernel pass, down to 1.
- R7: `busy` is high from the cycle after an accepted `start` through the `done` cycle. `done` is a single-cycle pulse. No memory access occurs while `busy` is low. A `start` that arrives while `busy` is high is ignored and leaves results and counts unchanged.
- R8: After reset, busy, done, mem_rd and mem_we are 0, and both counts are 0.
- R9: An accepted `start` clears both counts, so each run reports only its own accesses.
- R10: Inputs at full scale (+32767 and -32768 for 16-bit data) produce the model result of R2 with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; taken only when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| mem_rd | output | 1 | Read strobe; data returns next cycle |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | log2(N) | Sample address |
| mem_wre | output | DW | Write data, real part |
| mem_wim | output | DW | Write data, imaginary part |
| mem_rre | input | DW | Read data, real part |
| mem_rim | input | DW | Read data, imaginary part |
| rd_count | output | CW | Reads made in the current or last run |
| wr_count | output | CW | Writes made in the current or last run |

## Verification
The engine is run with N=32 and R=4, which has one prolog stage and two kernel passes. It is driven with these input patterns:
- All zeros, which exposes spurious data movement.
- A lone pair at addresses 0 and 16, which isolates the sum and difference rounding of the first butterfly.
- A full-scale constant, which probes the overflow margin of the halving.
- An alternating-sign pattern, which separates additions from subtractions.
- A ramp and several pseudo-random fills, which catch any wrong pairing of registers.

For every pattern, the recorded address sequence is compared with the breadth-first order computed in the bench. This tells a wrong stride or node order apart from an arithmetic error. One run pulses `start` in the middle of the run to show that the extra pulse is ignored. Back-to-back runs show that the counts restart from zero.

// File: rtl/w0tree_pkg.sv
package w0tree_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CALC,
        ST_STORE,
        ST_FINISH
    } tile_state_t;
endpackage

// File: rtl/w0_bfly_lane.sv
// One register lane of a tree level: upper half of a pair takes the halved sum,
// lower half takes the halved difference, unpaired lanes hold their value.
module w0_bfly_lane #(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] own_re,
    input  logic signed [DW-1:0] own_im,
    input  logic signed [DW-1:0] pair_re,
    input  logic signed [DW-1:0] pair_im,
    input  logic                 is_top,
    input  logic                 is_bot,
    output logic signed [DW-1:0] new_re,
    output logic signed [DW-1:0] new_im
);
    logic signed [DW:0] sum_re, sum_im, dif_re, dif_im;

    always_comb begin
        sum_re = {own_re[DW-1], own_re} + {pair_re[DW-1], pair_re};
        sum_im = {own_im[DW-1], own_im} + {pair_im[DW-1], pair_im};
        dif_re = {pair_re[DW-1], pair_re} - {own_re[DW-1], own_re};
        dif_im = {pair_im[DW-1], pair_im} - {own_im[DW-1], own_im};
        if (is_top) begin
            new_re = sum_re[DW:1];
            new_im = sum_im[DW:1];
        end else if (is_bot) begin
            new_re = dif_re[DW:1];
            new_im = dif_im[DW:1];
        end else begin
            new_re = own_re;
            new_im = own_im;
        end
    end
endmodule

// File: rtl/w0_node_addr.sv
// Address of point k of the current node: base = blk*span, stride = span/2
// in the prolog or span/R in the kernel.
module w0_node_addr #(
    parameter int AW = 5,
    parameter int SW = 3,
    parameter int KW = 3,
    parameter int J  = 2
) (
    input  logic [AW-1:0] blk,
    input  logic [SW-1:0] sh,
    input  logic [KW-1:0] k,
    input  logic          pro,
    output logic [AW-1:0] addr
);
    logic [SW-1:0] str;

    always_comb begin
        str  = pro ? (sh - SW'(1)) : (sh - SW'(J));
        addr = AW'((32'(blk) << sh) + (32'(k) << str));
    end
endmodule

// File: rtl/w0_tree_engine.sv
module w0_tree_engine
    import w0tree_pkg::*;
#(
    parameter int N_PTS  = 32,
    parameter int R_REGS = 4,
    parameter int DW     = 16,
    parameter int CW     = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    output logic                          busy,
    output logic                          done,
    output logic                          mem_rd,
    output logic                          mem_we,
    output logic [$clog2(N_PTS)-1:0]      mem_addr,
    output logic signed [DW-1:0]          mem_wre,
    output logic signed [DW-1:0]          mem_wim,
    input  logic signed [DW-1:0]          mem_rre,
    input  logic signed [DW-1:0]          mem_rim,
    output logic [CW-1:0]                 rd_count,
    output logic [CW-1:0]                 wr_count
);
    localparam int LOG_N   = $clog2(N_PTS);
    localparam int J       = $clog2(R_REGS);
    localparam int PRO_STG = LOG_N % J;
    localparam int KER_TOP = LOG_N - PRO_STG;
    localparam int AW      = LOG_N;
    localparam int SW      = $clog2(LOG_N + 1);
    localparam int KW      = J + 1;

    tile_state_t state, state_nx;

    logic [SW-1:0] sh;       // log2 of the current span
    logic [AW-1:0] blk;      // node index within the pass
    logic [KW-1:0] k;        // point index within the node
    logic [SW-1:0] lvl;      // log2 of the pair distance in CALC

    logic signed [DW-1:0] reg_re [R_REGS];
    logic signed [DW-1:0] reg_im [R_REGS];
    logic signed [DW-1:0] nxt_re [R_REGS];
    logic signed [DW-1:0] nxt_im [R_REGS];

    logic          pro;
    logic [KW-1:0] nsz;
    logic [KW-1:0] kp;
    logic [SW-1:0] first_lvl;
    logic [SW-1:0] dec;
    logic [SW-1:0] sh_next;
    logic          last_blk;
    logic          last_pt;
    logic [AW-1:0] node_addr;

    // Pass geometry
    always_comb begin
        pro       = (32'(sh) > KER_TOP);
        nsz       = pro ? KW'(2) : KW'(R_REGS);
        first_lvl = pro ? SW'(0) : SW'(J - 1);
        dec       = pro ? SW'(1) : SW'(J);
        sh_next   = sh - dec;
        last_blk  = (32'(blk) == ((32'd1 << (LOG_N - 32'(sh))) - 32'd1));
        last_pt   = (k == nsz - KW'(1));
        kp        = k - KW'(1);
    end

    w0_node_addr #(.AW(AW), .SW(SW), .KW(KW), .J(J)) u_addr (
        .blk  (blk),
        .sh   (sh),
        .k    (k),
        .pro  (pro),
        .addr (node_addr)
    );

    // One lane per register: pair distance m = 2^lvl, pairs (q, q+m) with q a multiple of 2m
    for (genvar gi = 0; gi < R_REGS; gi++) begin : g_lane
        logic [J-1:0] pidx;
        logic         is_top, is_bot;
        always_comb begin
            pidx   = J'(32'(gi) ^ (32'd1 << lvl));
            is_top = ((32'(gi) & ((32'd2 << lvl) - 32'd1)) == 32'd0);
            is_bot = ((32'(gi) & ((32'd2 << lvl) - 32'd1)) == (32'd1 << lvl));
        end
        w0_bfly_lane #(.DW(DW)) u_lane (
            .own_re  (reg_re[gi]),
            .own_im  (reg_im[gi]),
            .pair_re (reg_re[pidx]),
            .pair_im (reg_im[pidx]),
            .is_top  (is_top),
            .is_bot  (is_bot),
            .new_re  (nxt_re[gi]),
            .new_im  (nxt_im[gi])
        );
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_LOAD;
            ST_LOAD:   if (k == nsz) state_nx = ST_CALC;
            ST_CALC:   if (lvl == '0) state_nx = ST_STORE;
            ST_STORE:  if (last_pt)
                           state_nx = (last_blk && sh_next == '0) ? ST_FINISH : ST_LOAD;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath and traversal registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh       <= '0;
            blk      <= '0;
            k        <= '0;
            lvl      <= '0;
            rd_count <= '0;
            wr_count <= '0;
            for (int i = 0; i < R_REGS; i++) begin
                reg_re[i] <= '0;
                reg_im[i] <= '0;
            end
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        sh       <= SW'(LOG_N);
                        blk      <= '0;
                        k        <= '0;
                        rd_count <= '0;
                        wr_count <= '0;
                    end
                end
                ST_LOAD: begin
                    if (k != '0) begin
                        reg_re[kp[J-1:0]] <= mem_rre;
                        reg_im[kp[J-1:0]] <= mem_rim;
                    end
                    if (k == nsz) begin
                        k   <= '0;
                        lvl <= first_lvl;
                    end else begin
                        k        <= k + KW'(1);
                        rd_count <= rd_count + CW'(1);
                    end
                end
                ST_CALC: begin
                    for (int i = 0; i < R_REGS; i++) begin
                        reg_re[i] <= nxt_re[i];
                        reg_im[i] <= nxt_im[i];
                    end
                    if (lvl != '0) lvl <= lvl - SW'(1);
                end
                ST_STORE: begin
                    wr_count <= wr_count + CW'(1);
                    if (last_pt) begin
                        k <= '0;
                        if (last_blk) begin
                            blk <= '0;
                            sh  <= sh_next;
                        end else begin
                            blk <= blk + AW'(1);
                        end
                    end else begin
                        k <= k + KW'(1);
                    end
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        done     = (state == ST_FINISH);
        mem_rd   = (state == ST_LOAD) && (k != nsz);
        mem_we   = (state == ST_STORE);
        mem_addr = node_addr;
        mem_wre  = reg_re[k[J-1:0]];
        mem_wim  = reg_im[k[J-1:0]];
    end
endmodule

// File: rtl/w0_tree_engine_chk.sv
module w0_tree_engine_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          mem_rd,
    input logic          mem_we,
    input logic [CW-1:0] rd_count,
    input logic [CW-1:0] wr_count
);
    // R7: done lasts exactly one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: no memory traffic while idle
    p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd || mem_we));

    // R4: a cycle never reads and writes together
    p_rd_we_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_we));

    // R5: writes never run ahead of reads
    p_wr_le_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count <= rd_count);

    // R5: every point read is written back by the end of the run
    p_balanced_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_count == wr_count));

    // R9: an accepted start clears both counts and makes the engine busy
    p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && rd_count == '0 && wr_count == '0));

    // R7: a start during a run does not disturb the running count
    p_count_monotonic_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (rd_count >= $past(rd_count)));
endmodule

bind w0_tree_engine w0_tree_engine_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .mem_rd   (mem_rd),
    .mem_we   (mem_we),
    .rd_count (rd_count),
    .wr_count (wr_count)
);

// File: tb/w0_tree_engine_tb.sv
`timescale 1ns/1ps
module w0_tree_engine_tb;
    localparam int N     = 32;
    localparam int R     = 4;
    localparam int DW    = 16;
    localparam int CW    = 16;
    localparam int LOG_N = 5;
    localparam int J     = 2;
    localparam int PRO   = LOG_N % J;
    localparam int LIM   = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, mem_rd, mem_we;
    logic [LOG_N-1:0] mem_addr;
    logic signed [DW-1:0] mem_wre, mem_wim;
    logic signed [DW-1:0] mem_rre, mem_rim;
    logic [CW-1:0] rd_count, wr_count;

    always #2.5 clk = ~clk;

    w0_tree_engine #(.N_PTS(N), .R_REGS(R), .DW(DW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wre(mem_wre), .mem_wim(mem_wim), .mem_rre(mem_rre), .mem_rim(mem_rim),
        .rd_count(rd_count), .wr_count(wr_count)
    );

    logic signed [DW-1:0] mre [N];
    logic signed [DW-1:0] mim [N];
    int exp_re [N];
    int exp_im [N];
    int ex_addr [128];
    int ex_n;
    int rtr [128];
    int wtr [128];
    int rn, wn;
    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] seed = 32'h1234_5678;

    // Sample memory with one-cycle read latency; access trace recorder
    always @(posedge clk) begin
        if (mem_rd && rn < 128) begin
            rtr[rn] = int'(mem_addr);
            rn = rn + 1;
        end
        if (mem_we && wn < 128) begin
            wtr[wn] = int'(mem_addr);
            wn = wn + 1;
        end
        mem_rre <= mre[mem_addr];
        mem_rim <= mim[mem_addr];
        if (mem_we) begin
            mre[mem_addr] <= mem_wre;
            mim[mem_addr] <= mem_wim;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[31:16]));
    endfunction

    function automatic int pat_val(input int pat, input int idx, input int comp);
        case (pat)
            0: return 0;
            1: return (idx == 0) ? (comp == 0 ? 7 : -3) : ((idx == 16) ? (comp == 0 ? -4 : 5) : 0);
            2: return (comp == 0) ? 32767 : -32768;
            3: return ((idx % 2) == 0) ? 30000 : -30000;
            4: return (comp == 0) ? idx * 1000 - 16000 : 500 - idx * 37;
            default: return next_rand();
        endcase
    endfunction

    // Plain stage-by-stage unity-twiddle model (R1, R2)
    task automatic build_model();
        for (int s = 0; s < LOG_N; s++) begin
            int n3 = N >> s;
            int h = n3 / 2;
            for (int i0 = 0; i0 < N; i0 += n3) begin
                int a = exp_re[i0];
                int b = exp_re[i0 + h];
                int c = exp_im[i0];
                int d = exp_im[i0 + h];
                exp_re[i0]     = (a + b) >>> 1;
                exp_re[i0 + h] = (a - b) >>> 1;
                exp_im[i0]     = (c + d) >>> 1;
                exp_im[i0 + h] = (c - d) >>> 1;
            end
        end
    endtask

    // Breadth-first access order (R3, R4, R6)
    task automatic build_trace();
        int sh = LOG_N;
        ex_n = 0;
        for (int p = 0; p < PRO; p++) begin
            for (int b = 0; b < (N >> sh); b++) begin
                ex_addr[ex_n] = b << sh;
                ex_n = ex_n + 1;
                ex_addr[ex_n] = (b << sh) + (1 << (sh - 1));
                ex_n = ex_n + 1;
            end
            sh = sh - 1;
        end
        while (sh > 0) begin
            for (int b = 0; b < (N >> sh); b++) begin
                for (int kk = 0; kk < R; kk++) begin
                    ex_addr[ex_n] = (b << sh) + (kk << (sh - J));
                    ex_n = ex_n + 1;
                end
            end
            sh = sh - J;
        end
    endtask

    task automatic run_case(input int pat, input bit bump, input string req);
        int cyc;
        int bad;
        int first_i;
        for (int i = 0; i < N; i++) begin
            exp_re[i] = pat_val(pat, i, 0);
            exp_im[i] = pat_val(pat, i, 1);
            mre[i] = DW'(exp_re[i]);
            mim[i] = DW'(exp_im[i]);
        end
        build_model();
        build_trace();
        rn = 0;
        wn = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R7", "busy after start", int'(busy), 1);
        if (bump) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < LIM) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            chk(1'b0, "R7", "watchdog expired", cyc, LIM);
            return;
        end
        chk(int'(rd_count) == ex_n, "R5/R9", "read count", int'(rd_count), ex_n);
        chk(int'(wr_count) == ex_n, "R5/R9", "write count", int'(wr_count), ex_n);
        @(negedge clk);
        chk(!done && !busy, "R7", "done single pulse, idle after", int'(done) + int'(busy), 0);
        bad = 0;
        first_i = -1;
        for (int i = 0; i < N; i++) begin
            if (int'(mre[i]) != exp_re[i] || int'(mim[i]) != exp_im[i]) begin
                if (first_i < 0) first_i = i;
                bad++;
            end
        end
        if (first_i < 0)
            chk(1'b1, req, "data", 0, 0);
        else
            chk(1'b0, req, $sformatf("data at %0d (re)", first_i), int'(mre[first_i]), exp_re[first_i]);
        bad = 0;
        first_i = -1;
        for (int i = 0; i < ex_n; i++) begin
            if (i >= rn || rtr[i] != ex_addr[i]) begin
                if (first_i < 0) first_i = i;
                bad++;
            end
        end
        chk(bad == 0 && rn == ex_n, "R3/R4/R6", "read address order",
            (first_i < 0 || first_i >= rn) ? rn : rtr[first_i],
            (first_i < 0) ? ex_n : ex_addr[first_i]);
        bad = 0;
        first_i = -1;
        for (int i = 0; i < ex_n; i++) begin
            if (i >= wn || wtr[i] != ex_addr[i]) begin
                if (first_i < 0) first_i = i;
                bad++;
            end
        end
        chk(bad == 0 && wn == ex_n, "R4/R6", "write address order",
            (first_i < 0 || first_i >= wn) ? wn : wtr[first_i],
            (first_i < 0) ? ex_n : ex_addr[first_i]);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            mre[i] = '0;
            mim[i] = '0;
        end
        rn = 0;
        wn = 0;
        repeat (4) @(negedge clk);
        // R8: reset state
        chk(!busy && !done && !mem_rd && !mem_we && rd_count == '0 && wr_count == '0,
            "R8", "outputs in reset", int'(busy) + int'(done) + int'(mem_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && rd_count == '0, "R8", "idle after reset", int'(busy), 0);
        run_case(0, 1'b0, "R2");        // zeros
        run_case(1, 1'b0, "R1");        // lone butterfly pair, rounding
        run_case(2, 1'b0, "R10");       // full scale
        run_case(3, 1'b0, "R2");        // alternating sign
        run_case(4, 1'b0, "R2");        // ramp
        run_case(5, 1'b0, "R2");        // random
        run_case(6, 1'b1, "R7");        // random, extra start mid-run ignored
        run_case(7, 1'b0, "R9");        // random, back to back
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R7 global watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule